// File: doc/BRIEF.md
# HDLC Data Link Receiver with Message Ring

This block receives a bit-oriented HDLC data link that travels in overhead bit positions of a line frame. Each received bit comes with a one-cycle strobe. The receiver needs no start command. It locks onto opening flags and removes the zeros the transmitter inserted for transparency. It checks each message's frame check sequence and spots aborts and idle flag runs.

Every complete octet between flags goes into a small circular message buffer. This includes the two check octets at the end of a message. A processor reads the buffer through a synchronous read port. A status word gives the processor three sticky event flags and the index of the most recently written buffer location. The same cycle that reads the status also clears it.

An interrupt request is pending when any of these happens:
- a message ends;
- an abort is seen;
- idle flags are seen;
- a set number of octets has been stored since the last interrupt cause.

The request reaches its output only while two separate enables are both high.

Top module: `hdlc_dl_rx`

## Requirements
- R1: The receiver is driven only by `bit_in`/`bit_vld`. The bit pattern 0,1,1,1,1,1,1,0 (0x7E) is a flag, and the first flag seen outside a message opens one. No other control is needed before a well-formed message is received.
- R2: Inside a message, a 0 that follows five consecutive 1s is removed and is not part of the data. This holds wherever the run of 1s falls, including inside the check octets.
- R3: Data bits are packed least significant bit first (the first bit received becomes bit 0). Every completed octet between flags is written to the ring, the two check octets included. Writes go to consecutive locations and wrap from RING_DEPTH-1 to 0, with no limit on message length.
- R4: Reset sets the pointer to RING_DEPTH-1, so the first octet lands in location 0. After every write, the pointer holds the index of the location just written.
- R5: `rd_data` shows the ring location addressed by `rd_addr` one clock after the address is applied.
- R6: The check sequence is a CRC-16 with polynomial x^16+x^12+x^5+1, processed bit-reflected and preset to 0xFFFF, over all data bits including the check octets. A message whose final register value differs from 0xF0B8 sets the bad-check flag.
- R7: A message whose data bit count between flags is not a multiple of 8 sets the bad-check flag, whatever its CRC.
- R8: Seven consecutive 1s inside an open message are an abort. An abort sets the abort flag, drops any partial octet and closes the message. Further 1s, and 1s received while no message is open, raise no abort.
- R9: When two flags arrive with no data between them, the idle flag is set, unless the first of the two closed a message (a closing flag followed directly by an opening flag is not idle).
- R10: `status` is {pointer, idle, bad-check, abort}, with abort in bit 0, bad-check in bit 1, idle in bit 2, and the pointer in bits PTR_W+2:3. Each flag stays set until a cycle with `status_rd` high clears it. An event in that same cycle wins over the clear.
- R11: An interrupt becomes pending when any of these occurs:
  - a flag closes a message, good or bad;
  - an abort is detected;
  - an idle is detected;
  - the IRQ_BYTES-th octet has been written since the last such cause.

  A pending interrupt is cleared by `status_rd`.
- R12: `irq` is high only while the interrupt is pending and both `irq_en` and `dl_mode_en` are high. A pending interrupt is kept while the enables are low and appears once both are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Received data link bit |
| bit_vld | input | 1 | Strobe marking `bit_in` as a new bit |
| rd_addr | input | PTR_W (3) | Ring location to read |
| rd_data | output | 8 | Registered contents of the addressed location |
| status_rd | input | 1 | Status read strobe; clears flags and pending interrupt |
| status | output | PTR_W+3 (6) | {pointer, idle, bad-check, abort} |
| irq_en | input | 1 | Data link interrupt enable |
| dl_mode_en | input | 1 | Data link mode enable |
| irq | output | 1 | Gated interrupt request |

## Verification
The assertions watch the following on every cycle:
- the pointer steps by exactly one location for each stored octet and holds otherwise;
- flag, abort and message-end events never coincide;
- each event sets its own status bit and makes the interrupt pending;
- a status read with no concurrent event leaves the flags clear;
- the interrupt stays low whenever either enable is low.

Only the bench's scenarios can show the bit-level behaviour, which needs whole bit sequences. This covers zero removal, octet packing order, CRC acceptance and rejection, the non-octet length case, the single abort per run of 1s, the closing-then-opening flag exception to idle, and the octet-count interrupt.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  localparam int OCTET_W = 8;
  localparam int CRC_W   = 16;

  localparam logic [OCTET_W-1:0] FLAG_PAT    = 8'h7E;
  localparam logic [CRC_W-1:0]   CRC_PRESET  = 16'hFFFF;
  localparam logic [CRC_W-1:0]   CRC_POLY_RF = 16'h8408;
  localparam logic [CRC_W-1:0]   CRC_GOOD    = 16'hF0B8;

  // Events leaving the deframer, one cycle after the strobed bit.
  typedef struct packed {
    logic dat_vld;   // a destuffed data bit leaves the delay window
    logic dat_bit;
    logic flag;      // a flag completed on this bit
    logic was_open;  // a message was open before this flag
    logic abort;     // abort inside an open message
  } dfr_evt_t;

  // Events leaving the frame tracker, aligned with each other.
  typedef struct packed {
    logic               byte_wr;
    logic [OCTET_W-1:0] byte_val;
    logic               end_good;
    logic               end_bad;
    logic               end_idle;
    logic               abort;
  } trk_evt_t;

endpackage

// File: rtl/hdlc_deframer.sv
// Finds flags and aborts in the raw bit stream and removes stuffed zeros.
// Data bits are released after an octet-long delay, so a flag is
// recognised before any of its own bits could be taken as data.
module hdlc_deframer
  import hdlc_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     bit_in,
  input  logic     bit_vld,
  output dfr_evt_t evt_o
);

  localparam int WIN_W = OCTET_W;
  localparam int RUN_W = 3;
  localparam logic [RUN_W-1:0] RUN_STUFF = RUN_W'(5);
  localparam logic [RUN_W-1:0] RUN_ABORT = RUN_W'(6);
  localparam logic [RUN_W-1:0] RUN_SAT   = RUN_W'(7);

  logic [WIN_W-1:0] win_q;
  logic [WIN_W-1:0] keep_q;
  logic [RUN_W-1:0] ones_q;
  logic             open_q;

  logic [WIN_W-1:0] win_n;
  logic             stuffed;
  logic             flag_hit;
  logic             abort_hit;
  logic [RUN_W-1:0] ones_n;

  always_comb begin
    win_n     = {win_q[WIN_W-2:0], bit_in};
    stuffed   = !bit_in && (ones_q == RUN_STUFF);
    flag_hit  = (win_n == FLAG_PAT);
    abort_hit = bit_in && (ones_q == RUN_ABORT);
    if (!bit_in)              ones_n = '0;
    else if (ones_q == RUN_SAT) ones_n = RUN_SAT;
    else                      ones_n = ones_q + RUN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '0;
      keep_q <= '0;
      ones_q <= '0;
      open_q <= 1'b0;
      evt_o  <= '0;
    end else begin
      evt_o <= '0;
      if (bit_vld) begin
        win_q          <= win_n;
        ones_q         <= ones_n;
        evt_o.dat_vld  <= keep_q[WIN_W-1];
        evt_o.dat_bit  <= win_q[WIN_W-1];
        evt_o.flag     <= flag_hit;
        evt_o.was_open <= open_q;
        evt_o.abort    <= abort_hit && open_q;
        if (flag_hit || abort_hit) keep_q <= '0;
        else                       keep_q <= {keep_q[WIN_W-2:0], open_q && !stuffed};
        if (flag_hit)       open_q <= 1'b1;
        else if (abort_hit) open_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/hdlc_frame_track.sv
// Packs data bits into octets, runs the check sequence and classifies
// each flag as message end, idle or neither.
module hdlc_frame_track
  import hdlc_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  dfr_evt_t evt_i,
  output trk_evt_t trk_o
);

  localparam int CNT_W = $clog2(OCTET_W);

  logic [CRC_W-1:0]   crc_q, crc_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [OCTET_W-1:0] sh_q, sh_n;
  logic               has_q, has_n;
  logic               closed_q;
  logic               byte_done;
  logic               fb;

  always_comb begin
    fb        = crc_q[0] ^ evt_i.dat_bit;
    crc_n     = crc_q;
    cnt_n     = cnt_q;
    sh_n      = sh_q;
    has_n     = has_q;
    byte_done = 1'b0;
    if (evt_i.dat_vld) begin
      crc_n     = (crc_q >> 1) ^ (fb ? CRC_POLY_RF : '0);
      cnt_n     = cnt_q + CNT_W'(1);
      sh_n      = {evt_i.dat_bit, sh_q[OCTET_W-1:1]};
      has_n     = 1'b1;
      byte_done = (cnt_q == CNT_W'(OCTET_W-1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q    <= CRC_PRESET;
      cnt_q    <= '0;
      sh_q     <= '0;
      has_q    <= 1'b0;
      closed_q <= 1'b0;
      trk_o    <= '0;
    end else begin
      trk_o <= '0;
      if (evt_i.abort) begin
        crc_q       <= CRC_PRESET;
        cnt_q       <= '0;
        has_q       <= 1'b0;
        closed_q    <= 1'b0;
        trk_o.abort <= 1'b1;
      end else begin
        crc_q <= crc_n;
        cnt_q <= cnt_n;
        sh_q  <= sh_n;
        has_q <= has_n;
        if (byte_done) begin
          trk_o.byte_wr  <= 1'b1;
          trk_o.byte_val <= sh_n;
        end
        if (evt_i.flag) begin
          crc_q <= CRC_PRESET;
          cnt_q <= '0;
          has_q <= 1'b0;
          if (!evt_i.was_open) begin
            closed_q <= 1'b0;
          end else if (has_n) begin
            closed_q <= 1'b1;
            if ((cnt_n != '0) || (crc_n != CRC_GOOD)) trk_o.end_bad  <= 1'b1;
            else                                      trk_o.end_good <= 1'b1;
          end else if (closed_q) begin
            closed_q <= 1'b0;
          end else begin
            trk_o.end_idle <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/hdlc_msg_ring.sv
// Circular octet store with a last-written pointer and a registered read.
module hdlc_msg_ring #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [PTR_W-1:0]  last_ptr
);

  localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(DEPTH-1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  ptr_q;
  logic [PTR_W-1:0]  ptr_nx;

  assign ptr_nx   = (ptr_q == PTR_TOP) ? '0 : ptr_q + PTR_W'(1);
  assign last_ptr = ptr_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[ptr_nx] <= wr_data;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst)        ptr_q <= PTR_TOP;
    else if (wr_en) ptr_q <= ptr_nx;
  end

endmodule

// File: rtl/hdlc_dl_rx.sv
module hdlc_dl_rx
  import hdlc_rx_pkg::*;
#(
  parameter int  RING_DEPTH = 8,
  parameter int  IRQ_BYTES  = 4,
  localparam int PTR_W      = $clog2(RING_DEPTH),
  localparam int STAT_W     = PTR_W + 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_in,
  input  logic               bit_vld,
  input  logic [PTR_W-1:0]   rd_addr,
  output logic [OCTET_W-1:0] rd_data,
  input  logic               status_rd,
  output logic [STAT_W-1:0]  status,
  input  logic               irq_en,
  input  logic               dl_mode_en,
  output logic               irq
);

  localparam int BC_W = $clog2(IRQ_BYTES + 1);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(IRQ_BYTES - 1);

  dfr_evt_t          dfr_evt;
  trk_evt_t          trk_evt;
  logic [PTR_W-1:0]  ring_ptr;

  logic              abort_f, bad_f, idle_f;
  logic              irq_pend;
  logic [BC_W-1:0]   byte_cnt;
  logic              cause_evt;
  logic              cnt_hit;

  hdlc_deframer u_dfr (
    .clk     (clk),
    .rst     (rst),
    .bit_in  (bit_in),
    .bit_vld (bit_vld),
    .evt_o   (dfr_evt)
  );

  hdlc_frame_track u_trk (
    .clk   (clk),
    .rst   (rst),
    .evt_i (dfr_evt),
    .trk_o (trk_evt)
  );

  hdlc_msg_ring #(
    .DEPTH  (RING_DEPTH),
    .DATA_W (OCTET_W)
  ) u_ring (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (trk_evt.byte_wr),
    .wr_data  (trk_evt.byte_val),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .last_ptr (ring_ptr)
  );

  assign cause_evt = trk_evt.end_good | trk_evt.end_bad | trk_evt.end_idle | trk_evt.abort;
  assign cnt_hit   = trk_evt.byte_wr && (byte_cnt == BC_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      abort_f  <= 1'b0;
      bad_f    <= 1'b0;
      idle_f   <= 1'b0;
      irq_pend <= 1'b0;
      byte_cnt <= '0;
      irq      <= 1'b0;
    end else begin
      if (status_rd) begin
        abort_f  <= 1'b0;
        bad_f    <= 1'b0;
        idle_f   <= 1'b0;
        irq_pend <= 1'b0;
      end
      if (trk_evt.abort)    abort_f  <= 1'b1;
      if (trk_evt.end_bad)  bad_f    <= 1'b1;
      if (trk_evt.end_idle) idle_f   <= 1'b1;
      if (cause_evt || cnt_hit) irq_pend <= 1'b1;

      if (cause_evt || cnt_hit) byte_cnt <= '0;
      else if (trk_evt.byte_wr) byte_cnt <= byte_cnt + BC_W'(1);

      irq <= irq_pend && irq_en && dl_mode_en;
    end
  end

  assign status = {ring_ptr, idle_f, bad_f, abort_f};

endmodule

// File: rtl/hdlc_dl_rx_chk.sv
module hdlc_dl_rx_chk #(
  parameter int RING_DEPTH = 8,
  parameter int PTR_W      = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             irq,
  input logic             irq_en,
  input logic             dl_mode_en,
  input logic             status_rd,
  input logic [PTR_W+2:0] status,
  input logic             byte_wr,
  input logic             end_good,
  input logic             end_bad,
  input logic             end_idle,
  input logic             abort_ev,
  input logic             dfr_flag,
  input logic             dfr_abort,
  input logic             irq_pend
);

  logic [PTR_W-1:0] ptr;
  assign ptr = status[PTR_W+2:3];

  // R4: one step per stored octet, with wrap
  p_ptr_step_r4: assert property (@(posedge clk) disable iff (rst)
    byte_wr |=> ptr == (($past(ptr) == PTR_W'(RING_DEPTH-1)) ? '0 : $past(ptr) + PTR_W'(1)));

  // R4: pointer holds without a write
  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !byte_wr |=> $stable(ptr));

  // R6: message ends and aborts are mutually exclusive
  p_end_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({end_good, end_bad, end_idle, abort_ev}));

  // R8: a flag and an abort never complete on the same bit
  p_flag_abort_r8: assert property (@(posedge clk) disable iff (rst)
    !(dfr_flag && dfr_abort));

  // R8: abort event reaches status
  p_abort_flag_r8: assert property (@(posedge clk) disable iff (rst)
    abort_ev |=> status[0]);

  // R6: bad end reaches status
  p_bad_flag_r6: assert property (@(posedge clk) disable iff (rst)
    end_bad |=> status[1]);

  // R9: idle event reaches status
  p_idle_flag_r9: assert property (@(posedge clk) disable iff (rst)
    end_idle |=> status[2]);

  // R10: read with no concurrent event clears the flags
  p_rd_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (status_rd && !(abort_ev || end_bad || end_idle)) |=> status[2:0] == 3'b000);

  // R11: every cause leaves an interrupt pending
  p_cause_pend_r11: assert property (@(posedge clk) disable iff (rst)
    (abort_ev || end_idle || end_good || end_bad) |=> irq_pend);

  // R12: no interrupt unless both enables were high
  p_irq_gate_r12: assert property (@(posedge clk) disable iff (rst)
    !(irq_en && dl_mode_en) |=> !irq);

endmodule

bind hdlc_dl_rx hdlc_dl_rx_chk #(
  .RING_DEPTH (RING_DEPTH),
  .PTR_W      (PTR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq        (irq),
  .irq_en     (irq_en),
  .dl_mode_en (dl_mode_en),
  .status_rd  (status_rd),
  .status     (status),
  .byte_wr    (trk_evt.byte_wr),
  .end_good   (trk_evt.end_good),
  .end_bad    (trk_evt.end_bad),
  .end_idle   (trk_evt.end_idle),
  .abort_ev   (trk_evt.abort),
  .dfr_flag   (dfr_evt.flag),
  .dfr_abort  (dfr_evt.abort),
  .irq_pend   (irq_pend)
);

// File: tb/hdlc_dl_rx_tb.sv
`timescale 1ns/1ps
module hdlc_dl_rx_tb;

  localparam int DEPTH = 8;
  localparam int PW    = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bit_in = 1'b0;
  logic          bit_vld = 1'b0;
  logic [PW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          status_rd = 1'b0;
  logic [PW+2:0] status;
  logic          irq_en = 1'b1;
  logic          dl_mode_en = 1'b1;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;
  int tx_ones = 0;

  logic [7:0]    exp_mem [DEPTH];
  logic          exp_vld [DEPTH];
  logic [PW-1:0] exp_ptr = PW'(DEPTH-1);
  logic [7:0]    tx_buf [16];

  always #2.5 clk = ~clk;

  hdlc_dl_rx u_dut (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
    .rd_addr(rd_addr), .rd_data(rd_data), .status_rd(status_rd),
    .status(status), .irq_en(irq_en), .dl_mode_en(dl_mode_en), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_in  = b;
    bit_vld = 1'b1;
    @(negedge clk);
    bit_vld = 1'b0;
  endtask

  task automatic send_flag();
    send_bit(1'b0);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    send_bit(1'b0);
    tx_ones = 0;
  endtask

  task automatic send_dbit(input logic b);
    send_bit(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin
        send_bit(1'b0);
        tx_ones = 0;
      end
    end else begin
      tx_ones = 0;
    end
  endtask

  task automatic send_dbyte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_dbit(v[i]);
  endtask

  task automatic push(input logic [7:0] v);
    exp_ptr = (exp_ptr == PW'(DEPTH-1)) ? '0 : exp_ptr + PW'(1);
    exp_mem[exp_ptr] = v;
    exp_vld[exp_ptr] = 1'b1;
  endtask

  // opening flag, n octets from tx_buf, check octets, optional tail bits, closing flag
  task automatic send_frame(input int n, input logic corrupt, input int tail);
    logic [15:0] crc;
    logic        fb;
    logic [15:0] fcs;
    crc = 16'hFFFF;
    send_flag();
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 8; i++) begin
        fb  = crc[0] ^ tx_buf[k][i];
        crc = (crc >> 1) ^ (fb ? 16'h8408 : 16'h0000);
      end
      send_dbyte(tx_buf[k]);
      push(tx_buf[k]);
    end
    fcs = ~crc ^ (corrupt ? 16'h0001 : 16'h0000);
    send_dbyte(fcs[7:0]);
    push(fcs[7:0]);
    send_dbyte(fcs[15:8]);
    push(fcs[15:8]);
    for (int i = 0; i < tail; i++) send_dbit(i[0] ? 1'b0 : 1'b1);
    send_flag();
    settle();
  endtask

  task automatic read_status();
    @(negedge clk);
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
    settle();
  endtask

  task automatic chk_status(input string req, input int ab, input int bad, input int idl);
    chk({req, " abort"}, int'(status[0]), ab);
    chk({req, " badfcs"}, int'(status[1]), bad);
    chk({req, " idle"}, int'(status[2]), idl);
    chk({req, " ptr"}, int'(status[PW+2:3]), int'(exp_ptr));
  endtask

  task automatic chk_ring(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      if (exp_vld[a]) begin
        @(negedge clk);
        rd_addr = PW'(a);
        @(negedge clk);
        chk(req, int'(rd_data), int'(exp_mem[a]));
      end
    end
  endtask

  task automatic t_reset();
    chk("R4 reset ptr", int'(status[PW+2:3]), DEPTH - 1);
    chk("R10 reset flags", int'(status[2:0]), 0);
    chk("R12 reset irq", int'(irq), 0);
  endtask

  // R1 R2 R3 R5 R6: good message with stuffing-prone data
  task automatic t_good();
    tx_buf[0] = 8'hA5; tx_buf[1] = 8'hFF; tx_buf[2] = 8'h7E;
    send_frame(3, 1'b0, 0);
    chk_status("R1 R6 good frame", 0, 0, 0);
    chk("R11 irq after good end", int'(irq), 1);
    chk_ring("R2 R3 R5 ring data");
    read_status();
    chk("R11 irq cleared by read", int'(irq), 0);
  endtask

  task automatic t_bad_crc();
    tx_buf[0] = 8'h3C; tx_buf[1] = 8'hF8;
    send_frame(2, 1'b1, 0);
    chk_status("R6 corrupt check", 0, 1, 0);
    chk("R11 irq after bad end", int'(irq), 1);
    read_status();
    chk("R10 flags cleared", int'(status[2:0]), 0);
  endtask

  task automatic t_nonoctet();
    tx_buf[0] = 8'h01; tx_buf[1] = 8'h80;
    send_frame(2, 1'b0, 3);
    chk_status("R7 non-octet length", 0, 1, 0);
    read_status();
  endtask

  task automatic t_abort();
    send_flag();
    send_dbyte(8'h55);
    send_dbyte(8'hAA);
    push(8'h55);
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    settle();
    chk_status("R8 abort in message", 1, 0, 0);
    chk_ring("R8 octets before abort");
    read_status();
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    settle();
    chk("R8 no second abort", int'(status[0]), 0);
    tx_buf[0] = 8'h12; tx_buf[1] = 8'h9F;
    send_frame(2, 1'b0, 0);
    chk_status("R1 R8 recovery frame", 0, 0, 0);
    read_status();
  endtask

  task automatic t_idle();
    send_flag();
    settle();
    chk("R9 close then open not idle", int'(status[2]), 0);
    send_flag();
    settle();
    chk_status("R9 back-to-back flags", 0, 0, 1);
  endtask

  task automatic t_gate();
    read_status();
    irq_en = 1'b0;
    send_flag();
    settle();
    chk("R9 idle while gated", int'(status[2]), 1);
    chk("R12 irq_en low", int'(irq), 0);
    irq_en = 1'b1;
    settle();
    chk("R12 pending kept", int'(irq), 1);
    dl_mode_en = 1'b0;
    settle();
    chk("R12 dl_mode_en low", int'(irq), 0);
    dl_mode_en = 1'b1;
    read_status();
    chk("R11 pending cleared", int'(irq), 0);
  endtask

  task automatic t_count();
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    settle();
    read_status();
    send_flag();
    send_dbyte(8'h12); send_dbyte(8'h34); send_dbyte(8'h56); send_dbyte(8'h78);
    push(8'h12); push(8'h34); push(8'h56);
    settle();
    chk("R11 three octets no irq", int'(irq), 0);
    send_dbyte(8'h9A);
    push(8'h78);
    settle();
    chk("R11 fourth octet irq", int'(irq), 1);
    chk("R4 ptr after four", int'(status[PW+2:3]), int'(exp_ptr));
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    settle();
    chk("R8 abort drops partial", int'(status[PW+2:3]), int'(exp_ptr));
    read_status();
  endtask

  task automatic t_wrap();
    tx_buf[0] = 8'h00; tx_buf[1] = 8'hFF; tx_buf[2] = 8'h0F; tx_buf[3] = 8'hF0;
    tx_buf[4] = 8'hC3; tx_buf[5] = 8'h7E; tx_buf[6] = 8'h81; tx_buf[7] = 8'hBD;
    tx_buf[8] = 8'h42;
    send_frame(9, 1'b0, 0);
    chk_status("R3 long message wraps", 0, 0, 0);
    chk_ring("R3 R5 wrapped ring");
    read_status();
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) exp_vld[a] = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_good();
    t_bad_crc();
    t_nonoctet();
    t_abort();
    t_idle();
    t_gate();
    t_count();
    t_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule